// File: doc/BRIEF.md
# GFP Frame-Mapped Encapsulator

This block turns client Ethernet frames into frame-mapped GFP frames on a byte-wide line. A client frame comes in as a byte stream marked with start and end flags and is held in a single frame store. When the whole frame is in the store, the block knows the payload length. At the next frame boundary on the line, it sends a core header that carries that length and its check field. The payload area follows. It holds an optional four-byte line header, the payload type header, an extension header in linear mode, the client bytes, and an optional payload FCS.

The output carries one byte on every clock, with no stuffing of any kind, and frames follow each other back to back. While no client frame is ready, the block sends four-byte idle frames. Every payload-area byte passes through a self-synchronous x^43+1 scrambler. The scrambler's state carries over from one frame to the next. The header mode, line header insertion, FCS suppression and scrambler bypass come from static control inputs. All of them default to zero: null mode, FCS appended, scrambling on.

Top module: `gfp_encap`

## Requirements
- R1: After reset, and whenever no client frame is held, the output carries idle frames: the four bytes B6, AB, 31, E0, with out_sof high on the first byte only, repeating without gaps.
- R2: Each data frame starts with a core header of four bytes, unscrambled. The header holds the PLI (the payload-area byte count) MSB first, then a cHEC computed as CRC-16 (x^16+x^12+x^5+1, initial value 0, MSB first) over the PLI. All four bytes are XORed with B6AB31E0.
- R3: The payload type header is four bytes. Byte 0 is {3'b000, PFI, 3'b000, EXI bit}, where PFI is 1 when an FCS is appended and the EXI bit is 1 in linear mode. Byte 1 is 0x01. The last two bytes are the CRC-16 of the first two.
- R4: In linear mode (cfg_linear=1), an extension header {chan_id, 0x00, CRC-16 of those two bytes} follows the type header. In null mode there is none.
- R5: With cfg_lhdr_en=1, the four bytes of line_hdr (MSB first) sit directly after the core header, ahead of the type header.
- R6: The payload FCS is a reflected CRC-32 (polynomial 0x04C11DB7, initial all ones, complemented). It covers only the client bytes and is sent least significant byte first. Without a line header, its coverage starts at the 9th frame byte in null mode and at the 13th in linear mode.
- R7: With cfg_fcs_off=1, no FCS is sent, the PLI is 4 smaller, and PFI is 0.
- R8: Payload-area bytes are scrambled MSB first with x^43+1 (each sent bit is the data bit XOR the sent bit 43 positions earlier). The scrambler state starts at zero at reset and carries over between frames.
- R9: With cfg_scr_off=1, payload-area bytes are sent unchanged, but they still shift into the scrambler state.
- R10: in_ready is high after reset. It drops after the byte flagged in_eof is accepted and rises again by the cycle that puts the frame's last byte on the output.
- R11: A frame longer than BUF_DEPTH bytes is truncated to its first BUF_DEPTH bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Client byte valid |
| in_data | input | 8 | Client byte |
| in_sof | input | 1 | First byte of a client frame |
| in_eof | input | 1 | Last byte of a client frame |
| in_ready | output | 1 | Frame store can accept bytes |
| cfg_linear | input | 1 | 1 = linear extension header mode, 0 = null mode |
| cfg_lhdr_en | input | 1 | Insert the four-byte line header |
| cfg_fcs_off | input | 1 | Suppress the payload FCS |
| cfg_scr_off | input | 1 | Bypass payload scrambling |
| line_hdr | input | 32 | Line header value |
| chan_id | input | 8 | Channel identifier for the linear extension header |
| out_data | output | 8 | Line byte |
| out_sof | output | 1 | First byte of a GFP frame (data or idle) |

## Verification
A table of client frames covers each header mode with and without the line header, the FCS appended and suppressed, scrambling on and off, and a single-byte frame. Each entry tells the four header layouts apart by where the type header, extension header, client bytes and FCS land against the received PLI. The bench descrambles the stream with its own history, which runs through every frame. A design that reset its scrambler per frame, or failed to record bypassed bytes, corrupts the frames that follow. Directed cases cover the idle stream after reset, the in_ready timing around a held frame, and a client frame longer than the store.

// File: rtl/gfp_encap_pkg.sv
package gfp_encap_pkg;

  typedef enum logic [2:0] {
    SEG_CORE, SEG_LHDR, SEG_TYPE, SEG_EXT, SEG_PAY, SEG_FCS
  } seg_t;

  localparam logic [31:0] CORE_MASK = 32'hB6AB31E0;

  // CRC-16 x^16+x^12+x^5+1 over a 16-bit word, initial value zero, MSB first
  function automatic logic [15:0] crc16_w(input logic [15:0] d);
    logic [15:0] c;
    logic fb;
    c = 16'h0000;
    for (int i = 15; i >= 0; i--) begin
      fb = c[15] ^ d[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  // Reflected CRC-32 update by one byte, LSB first
  function automatic logic [31:0] crc32_b(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    logic fb;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ d[i];
      c  = c >> 1;
      if (fb) c = c ^ 32'hEDB88320;
    end
    return c;
  endfunction

  // Payload-area length for a client frame of n bytes
  function automatic logic [15:0] pli_calc(input logic [15:0] n, input logic lin,
                                           input logic lhe, input logic fcs_off);
    logic [15:0] p;
    p = n + 16'd4;
    if (lin) p = p + 16'd4;
    if (lhe) p = p + 16'd4;
    if (!fcs_off) p = p + 16'd4;
    return p;
  endfunction

endpackage

// File: rtl/gfp_frame_store.sv
module gfp_frame_store #(
  parameter int BUF_DEPTH = 64,
  localparam int AW = $clog2(BUF_DEPTH),
  localparam int CW = $clog2(BUF_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_sof,
  input  logic          in_eof,
  output logic          in_ready,
  input  logic          release_i,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          frame_ready,
  output logic [CW-1:0] frame_len
);

  logic [7:0]    mem [BUF_DEPTH];
  logic [CW-1:0] cnt, cnt_nx;
  logic          acc, room, wr_en;
  logic [AW-1:0] waddr;

  assign in_ready = !frame_ready;
  assign acc      = in_valid && in_ready;
  assign room     = cnt < CW'(BUF_DEPTH);
  assign wr_en    = acc && (in_sof || room);
  assign waddr    = in_sof ? '0 : cnt[AW-1:0];
  assign cnt_nx   = in_sof ? CW'(1) : (room ? cnt + CW'(1) : cnt);
  assign rd_data  = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[waddr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= '0;
      frame_ready <= 1'b0;
      frame_len   <= '0;
    end else begin
      if (acc) cnt <= cnt_nx;
      if (release_i) begin
        frame_ready <= 1'b0;
      end else if (acc && in_eof) begin
        frame_ready <= 1'b1;
        frame_len   <= cnt_nx;
      end
    end
  end

  // R10: a held frame stays held until the sequencer releases it
  p_hold_until_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ready && !release_i |=> frame_ready);

  // R11: a held frame never exceeds the store
  p_len_in_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ready |-> (frame_len != '0) && (frame_len <= CW'(BUF_DEPTH)));

endmodule

// File: rtl/gfp_seq.sv
module gfp_seq
  import gfp_encap_pkg::*;
#(
  parameter int BUF_DEPTH = 64,
  localparam int AW = $clog2(BUF_DEPTH),
  localparam int CW = $clog2(BUF_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_ready,
  input  logic [CW-1:0] frame_len,
  input  logic          cfg_linear,
  input  logic          cfg_lhdr_en,
  input  logic          cfg_fcs_off,
  input  logic          cfg_scr_off,
  input  logic [31:0]   line_hdr,
  input  logic [7:0]    chan_id,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          release_o,
  output logic [7:0]    byte_o,
  output logic          sof_o,
  output logic          area_o,
  output logic          scr_off_o
);

  seg_t          seg;
  logic [CW-1:0] idx, len_q;
  logic          is_data, lin_q, lhe_q, fcs_off_q, scr_off_q;
  logic [15:0]   pli_q;
  logic [31:0]   crc_q, fcs, word;
  logic [7:0]    tb0;
  logic          last_hdr, last_pay, frame_end, take;
  logic [1:0]    sel;

  assign last_hdr  = idx[1:0] == 2'd3;
  assign last_pay  = idx == len_q - CW'(1);
  assign frame_end = (seg == SEG_CORE && last_hdr && !is_data)
                   || (seg == SEG_PAY && last_pay && fcs_off_q)
                   || (seg == SEG_FCS && last_hdr);
  assign release_o = frame_end && is_data;
  assign take      = frame_ready && !release_o;

  assign tb0 = {3'b000, !fcs_off_q, 3'b000, lin_q};
  assign fcs = ~crc_q;

  always_comb begin
    case (seg)
      SEG_CORE: word = {pli_q, crc16_w(pli_q)} ^ CORE_MASK;
      SEG_LHDR: word = line_hdr;
      SEG_TYPE: word = {tb0, 8'h01, crc16_w({tb0, 8'h01})};
      SEG_EXT:  word = {chan_id, 8'h00, crc16_w({chan_id, 8'h00})};
      SEG_FCS:  word = {fcs[7:0], fcs[15:8], fcs[23:16], fcs[31:24]};
      default:  word = '0;
    endcase
  end

  assign sel       = 2'd3 - idx[1:0];
  assign byte_o    = (seg == SEG_PAY) ? rd_data : word[{sel, 3'b000} +: 8];
  assign sof_o     = (seg == SEG_CORE) && (idx == '0);
  assign area_o    = seg != SEG_CORE;
  assign rd_addr   = idx[AW-1:0];
  assign scr_off_o = scr_off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg       <= SEG_CORE;
      idx       <= '0;
      is_data   <= 1'b0;
      lin_q     <= 1'b0;
      lhe_q     <= 1'b0;
      fcs_off_q <= 1'b0;
      scr_off_q <= 1'b0;
      len_q     <= '0;
      pli_q     <= '0;
      crc_q     <= '1;
    end else begin
      if (seg == SEG_PAY) crc_q <= crc32_b(crc_q, rd_data);
      else if (seg != SEG_FCS) crc_q <= '1;

      if (frame_end) begin
        seg       <= SEG_CORE;
        idx       <= '0;
        is_data   <= take;
        lin_q     <= cfg_linear;
        lhe_q     <= cfg_lhdr_en;
        fcs_off_q <= cfg_fcs_off;
        scr_off_q <= cfg_scr_off;
        len_q     <= frame_len;
        pli_q     <= take ? pli_calc(16'(frame_len), cfg_linear, cfg_lhdr_en, cfg_fcs_off)
                          : 16'd0;
      end else begin
        idx <= idx + CW'(1);
        case (seg)
          SEG_CORE: if (last_hdr) begin idx <= '0; seg <= lhe_q ? SEG_LHDR : SEG_TYPE; end
          SEG_LHDR: if (last_hdr) begin idx <= '0; seg <= SEG_TYPE; end
          SEG_TYPE: if (last_hdr) begin idx <= '0; seg <= lin_q ? SEG_EXT : SEG_PAY; end
          SEG_EXT:  if (last_hdr) begin idx <= '0; seg <= SEG_PAY; end
          SEG_PAY:  if (last_pay) begin idx <= '0; seg <= SEG_FCS; end
          default: ;
        endcase
      end
    end
  end

  // R1: idle frames carry a zero length
  p_idle_zero_pli_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == SEG_CORE) && !is_data |-> pli_q == 16'd0);

  // R10: the frame store is released for exactly one cycle
  p_release_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    release_o |=> !release_o);

  // R6: the FCS segment only follows a frame that asked for one
  p_fcs_when_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seg == SEG_FCS |-> !fcs_off_q && is_data);

endmodule

// File: rtl/gfp_scrambler.sv
module gfp_scrambler (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] byte_i,
  input  logic       sof_i,
  input  logic       area_i,
  input  logic       off_i,
  output logic [7:0] out_data,
  output logic       out_sof
);

  logic [42:0] hist, hist_nx, h;
  logic [7:0]  scr;
  logic        b;

  always_comb begin
    h = hist;
    for (int i = 7; i >= 0; i--) begin
      b      = off_i ? byte_i[i] : (byte_i[i] ^ h[42]);
      scr[i] = b;
      h      = {h[41:0], b};
    end
    hist_nx = area_i ? h : hist;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist     <= '0;
      out_data <= 8'h00;
      out_sof  <= 1'b0;
    end else begin
      hist     <= hist_nx;
      out_data <= area_i ? scr : byte_i;
      out_sof  <= sof_i;
    end
  end

  // R2: core header bytes leave unscrambled
  p_core_plain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !area_i |=> out_data == $past(byte_i));

  // R9: bypass passes payload bytes unchanged
  p_bypass_plain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    area_i && off_i |=> out_data == $past(byte_i));

  // R8: the history ends with the byte just sent
  p_hist_tracks_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    area_i |=> hist[7:0] == out_data);

endmodule

// File: rtl/gfp_encap.sv
module gfp_encap #(
  parameter int BUF_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_sof,
  input  logic        in_eof,
  output logic        in_ready,
  input  logic        cfg_linear,
  input  logic        cfg_lhdr_en,
  input  logic        cfg_fcs_off,
  input  logic        cfg_scr_off,
  input  logic [31:0] line_hdr,
  input  logic [7:0]  chan_id,
  output logic [7:0]  out_data,
  output logic        out_sof
);

  localparam int AW = $clog2(BUF_DEPTH);
  localparam int CW = $clog2(BUF_DEPTH + 1);

  logic          frame_ready, release_w, sof_w, area_w, scr_off_w;
  logic [CW-1:0] frame_len;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data, byte_w;

  gfp_frame_store #(.BUF_DEPTH(BUF_DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_ready(in_ready),
    .release_i(release_w), .rd_addr(rd_addr), .rd_data(rd_data),
    .frame_ready(frame_ready), .frame_len(frame_len)
  );

  gfp_seq #(.BUF_DEPTH(BUF_DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .frame_ready(frame_ready), .frame_len(frame_len),
    .cfg_linear(cfg_linear), .cfg_lhdr_en(cfg_lhdr_en), .cfg_fcs_off(cfg_fcs_off),
    .cfg_scr_off(cfg_scr_off), .line_hdr(line_hdr), .chan_id(chan_id),
    .rd_data(rd_data), .rd_addr(rd_addr), .release_o(release_w),
    .byte_o(byte_w), .sof_o(sof_w), .area_o(area_w), .scr_off_o(scr_off_w)
  );

  gfp_scrambler u_scr (
    .clk(clk), .rst_n(rst_n), .byte_i(byte_w), .sof_i(sof_w), .area_i(area_w),
    .off_i(scr_off_w), .out_data(out_data), .out_sof(out_sof)
  );

  // R10: release of the store only ever follows a held frame
  p_release_needs_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    release_w |-> frame_ready);

endmodule

// File: tb/tb_gfp_encap.sv
module tb_gfp_encap;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic        cfg_linear = 1'b0, cfg_lhdr_en = 1'b0, cfg_fcs_off = 1'b0, cfg_scr_off = 1'b0;
  logic [31:0] line_hdr = 32'hC0DE_F00D;
  logic [7:0]  chan_id = 8'h3C;
  logic [7:0]  out_data;
  logic        out_sof;

  always #5 clk = ~clk;

  gfp_encap dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_ready(in_ready),
    .cfg_linear(cfg_linear), .cfg_lhdr_en(cfg_lhdr_en), .cfg_fcs_off(cfg_fcs_off),
    .cfg_scr_off(cfg_scr_off), .line_hdr(line_hdr), .chan_id(chan_id),
    .out_data(out_data), .out_sof(out_sof)
  );

  // {linear, line header, fcs off, scrambler off, length[7:0], seed[7:0]}
  localparam int NV = 6;
  localparam logic [19:0] VEC [NV] = '{
    {4'b0000, 8'd20, 8'h11},
    {4'b1000, 8'd33, 8'h5A},
    {4'b0100, 8'd8,  8'hE0},
    {4'b0010, 8'd15, 8'h02},
    {4'b1111, 8'd1,  8'h9C},
    {4'b0001, 8'd64, 8'h40}
  };

  int checks = 0, fails = 0;
  logic [7:0]  rx [0:255];
  logic [7:0]  pl [0:127];
  logic [15:0] got_pli, got_chec;
  logic [42:0] dh = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc16(input logic [15:0] d);
    logic [31:0] r;
    r = {d, 16'h0000};
    for (int i = 31; i >= 16; i--)
      if (r[i]) r = r ^ (32'h00011021 << (i - 16));
    return r[15:0];
  endfunction

  function automatic logic [31:0] ref_fcs(input int n);
    logic [31:0] r;
    r = 32'hFFFFFFFF;
    for (int k = 0; k < n; k++)
      for (int j = 0; j < 8; j++)
        r = (r[0] ^ pl[k][j]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return ~r;
  endfunction

  task automatic send(input int n, input logic [7:0] seed);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 8'(seed + 8'(k * 7));
      in_sof   = (k == 0);
      in_eof   = (k == n - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  // Waits for the next data frame; descrambles its payload area into rx
  task automatic grab(input bit scr_off);
    logic [7:0] h [4];
    bit done;
    done = 0;
    while (!done) begin
      @(negedge clk);
      while (!out_sof) @(negedge clk);
      h[0] = out_data;
      for (int k = 1; k < 4; k++) begin @(negedge clk); h[k] = out_data; end
      got_pli  = {h[0] ^ 8'hB6, h[1] ^ 8'hAB};
      got_chec = {h[2] ^ 8'h31, h[3] ^ 8'hE0};
      if (got_pli != 16'd0) begin
        for (int k = 0; k < int'(got_pli) && k < 256; k++) begin
          @(negedge clk);
          for (int j = 7; j >= 0; j--) begin
            rx[k][j] = scr_off ? out_data[j] : (out_data[j] ^ dh[42]);
            dh = {dh[41:0], out_data[j]};
          end
        end
        done = 1;
      end
    end
  endtask

  task automatic check_frame(input bit lin, input bit lhe, input bit fcs_off, input int n);
    int pos, bad;
    logic [7:0]  tb0;
    logic [31:0] f;
    pos = 0;
    chk(got_pli == 16'(n + 4 + (lin ? 4 : 0) + (lhe ? 4 : 0) + (fcs_off ? 0 : 4)),
        "R2 pli", 32'(got_pli), 32'(n));
    chk(got_chec == ref_crc16(got_pli), "R2 chec", 32'(got_chec), 32'(ref_crc16(got_pli)));
    if (lhe) begin
      chk({rx[0], rx[1], rx[2], rx[3]} == line_hdr, "R5 line header",
          {rx[0], rx[1], rx[2], rx[3]}, line_hdr);
      pos = 4;
    end
    tb0 = {3'b000, !fcs_off, 3'b000, lin};
    chk({rx[pos], rx[pos+1], rx[pos+2], rx[pos+3]} == {tb0, 8'h01, ref_crc16({tb0, 8'h01})},
        "R3 type header", {rx[pos], rx[pos+1], rx[pos+2], rx[pos+3]},
        {tb0, 8'h01, ref_crc16({tb0, 8'h01})});
    chk(rx[pos][4] == !fcs_off, "R7 pfi", 32'(rx[pos][4]), 32'(!fcs_off));
    pos += 4;
    if (lin) begin
      chk({rx[pos], rx[pos+1], rx[pos+2], rx[pos+3]} == {chan_id, 8'h00, ref_crc16({chan_id, 8'h00})},
          "R4 extension header", {rx[pos], rx[pos+1], rx[pos+2], rx[pos+3]},
          {chan_id, 8'h00, ref_crc16({chan_id, 8'h00})});
      pos += 4;
    end
    bad = 0;
    for (int k = 0; k < n; k++) if (rx[pos + k] !== pl[k]) bad++;
    chk(bad == 0, "R8 R9 payload bytes", 32'(bad), 32'd0);
    if (!fcs_off) begin
      f = ref_fcs(n);
      chk({rx[pos+n+3], rx[pos+n+2], rx[pos+n+1], rx[pos+n]} == f, "R6 fcs",
          {rx[pos+n+3], rx[pos+n+2], rx[pos+n+1], rx[pos+n]}, f);
    end
  endtask

  task automatic run_frame(input bit lin, input bit lhe, input bit fcs_off, input bit scr_off,
                           input int n, input logic [7:0] seed);
    int stored;
    cfg_linear = lin; cfg_lhdr_en = lhe; cfg_fcs_off = fcs_off; cfg_scr_off = scr_off;
    stored = (n > 64) ? 64 : n;
    for (int k = 0; k < stored; k++) pl[k] = 8'(seed + 8'(k * 7));
    send(n, seed);
    chk(in_ready == 1'b0, "R10 ready low while held", 32'(in_ready), 32'd0);
    grab(scr_off);
    chk(in_ready == 1'b1, "R10 ready back after last byte", 32'(in_ready), 32'd1);
    check_frame(lin, lhe, fcs_off, stored);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] seen [12];
    logic [11:0] sofs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(in_ready == 1'b1, "R10 ready after reset", 32'(in_ready), 32'd1);

    // R1: idle stream after reset
    @(negedge clk);
    while (!out_sof) @(negedge clk);
    for (int k = 0; k < 12; k++) begin
      seen[k] = out_data; sofs[k] = out_sof;
      @(negedge clk);
    end
    for (int k = 0; k < 12; k++) begin
      logic [7:0] e;
      e = (k % 4 == 0) ? 8'hB6 : (k % 4 == 1) ? 8'hAB : (k % 4 == 2) ? 8'h31 : 8'hE0;
      chk(seen[k] == e, "R1 idle byte", 32'(seen[k]), 32'(e));
    end
    chk(sofs == 12'b0001_0001_0001, "R1 idle sof spacing", 32'(sofs), 32'h111);

    // Table of configurations
    for (int v = 0; v < NV; v++)
      run_frame(VEC[v][19], VEC[v][18], VEC[v][17], VEC[v][16],
                int'(VEC[v][15:8]), VEC[v][7:0]);

    // R8: scrambled frame right after a bypassed one relies on carried state
    run_frame(1'b0, 1'b0, 1'b0, 1'b0, 12, 8'hA5);

    // R11: oversize frame is cut to the store depth
    run_frame(1'b1, 1'b1, 1'b0, 1'b0, 70, 8'h07);

    // R1: line returns to idle frames once nothing is held
    @(negedge clk);
    while (!out_sof) @(negedge clk);
    chk(out_data == 8'hB6, "R1 idle after traffic", 32'(out_data), 32'hB6);
    @(negedge clk);
    chk(out_data == 8'hAB, "R1 idle pli low", 32'(out_data), 32'hAB);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule